// File: doc/BRIEF.md
# I2C Master Start and Address Phase Engine

This block is the master-side front end of a register-driven I2C controller. It watches the SCL and SDA lines to tell whether the bus is in use. Software loads an address byte and then issues a single control write that sets the master, transmit, busy and pending fields together. If the bus is idle, the engine puts a START on the bus and shifts out the byte. The byte holds a 7-bit target address in bits 7..1 and the read/write direction in bit 0. The engine then releases SDA for the acknowledge slot and samples it.

On the falling edge of the ninth SCL clock the engine clears its pending flag, which raises the interrupt, and holds SCL low. The clock stays stretched until software answers. The engine records the sampled acknowledge level. Only if the target acknowledged does it set the transmit status to the inverse of the direction bit. Software ends the exchange with a control write that sets the pending field to 1 and the busy field to 0. This produces a STOP, and the bus returns to idle.

The SCL timing comes from one half-period counter of `HALF_DIV` system clocks. The counter holds its value while SCL is stretched. Both lines are open-drain: an `_oe_o` output at 1 pulls the line low.

Top module: `i2c_addr_master`

## Requirements
- R1: After reset, both line pull-downs are off, busy_o is 0, pin_o is 1, irq_o is 0, trx_o is 0 and lrb_o is 0.
- R2: A transfer starts only on a control write with ctrl_mst_i, ctrl_trx_i, ctrl_bb_i and ctrl_pin_i all 1 while busy_o is 0. A write with any of these fields 0 causes no line activity.
- R3: busy_o goes to 1 after SDA falls while SCL is high, and returns to 0 after SDA rises while SCL is high. This holds whichever master drives the lines.
- R4: After START, the engine sends the data register byte MSB first, so bit 0 (the direction) goes last. SDA does not change while SCL is high during the address bits.
- R5: During the address phase, every SCL high phase and every SCL low phase lasts exactly HALF_DIV clock cycles.
- R6: During the ninth clock the engine does not drive SDA. The SDA level it samples in that high phase goes to lrb_o, where 0 means ACK and 1 means NACK.
- R7: pin_o falls and irq_o rises on the ninth SCL falling edge. SCL stays low for as long as pin_o is 0.
- R8: On ACK, trx_o becomes the inverse of the direction bit. For example, 0xCB gives trx_o = 0. On NACK, trx_o keeps the value 1 that the start command set.
- R9: While the clock is stretched, a control write with ctrl_pin_i = 1 and ctrl_bb_i = 0 sets pin_o to 1. The engine then drives a STOP: SDA rises while SCL is high, and busy_o returns to 0.
- R10: A start command written while another master holds the bus busy is dropped. It causes no line activity, during the busy period or after the bus frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_we_i | input | 1 | Write strobe for the data register |
| data_i | input | 8 | Address byte: bits 7..1 address, bit 0 direction |
| ctrl_we_i | input | 1 | Write strobe for the control fields |
| ctrl_mst_i | input | 1 | Control field: master select |
| ctrl_trx_i | input | 1 | Control field: transmit select |
| ctrl_bb_i | input | 1 | Control field: bus busy (1 = start, 0 = stop) |
| ctrl_pin_i | input | 1 | Control field: pending flag write-back |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Bus busy status |
| pin_o | output | 1 | Pending flag, 0 while service is pending |
| trx_o | output | 1 | Transfer direction status, 1 = transmit |
| lrb_o | output | 1 | Acknowledge level sampled in the ninth clock |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the engine with HALF_DIV = 4 and SYNC_STAGES = 2. With these values a full address phase takes about eighty cycles, so dozens of random addresses, directions and acknowledge choices fit in the run. The short half period also lets the bench count the exact length of every SCL phase in cycles. Two synchronizer stages keep the line-sampling delay well inside one half period, so a modelled target can drive ACK after it sees the eighth falling edge and the engine still samples it in time. The same bench drives a START and STOP of its own as a foreign master to exercise busy detection and the dropped command.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_BIT_LO, S_BIT_HI, S_ACK_LO, S_ACK_HI,
    S_WAIT, S_STOP_LO, S_STOP_HI, S_STOP_REL
  } state_e;
endpackage

// File: rtl/i2cm_line_mon.sv
module i2cm_line_mon #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic busy_o
);
  logic [1:0] raw;
  logic [1:0] sync;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [STAGES-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '1;
      else         q <= {q[STAGES-2:0], raw[g]};
    end
    assign sync[g] = q[STAGES-1];
  end

  logic scl_s, sda_s, scl_p, sda_p, busy_q;
  logic start_det, stop_det;
  assign scl_s = sync[1];
  assign sda_s = sync[0];
  // edges count only when SCL is high in both samples
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
      if (start_det)     busy_q <= 1'b1;
      else if (stop_det) busy_q <= 1'b0;
    end
  end

  assign sda_o  = sda_s;
  assign busy_o = busy_q;

  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> busy_o); // R3
  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !busy_o); // R3
endmodule

// File: rtl/i2cm_half_timer.sv
module i2cm_half_timer #(
  parameter int unsigned HALF_DIV = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5
  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/i2c_addr_master.sv
module i2c_addr_master
  import i2cm_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       data_we_i,
  input  logic [7:0] data_i,
  input  logic       ctrl_we_i,
  input  logic       ctrl_mst_i,
  input  logic       ctrl_trx_i,
  input  logic       ctrl_bb_i,
  input  logic       ctrl_pin_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       pin_o,
  output logic       trx_o,
  output logic       lrb_o,
  output logic       irq_o
);
  localparam int unsigned BITS = 8;
  localparam int unsigned BW   = $clog2(BITS);

  state_e          state_q;
  logic [BITS-1:0] dbr_q, shift_q;
  logic [BW-1:0]   bit_q;
  logic            dir_q, pin_q, trx_q, lrb_q, sda_oe_q, sda_nxt;
  logic            sda_s, busy, tick, tmr_en, start_go, stop_go;

  i2cm_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk_i (clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o (sda_s), .busy_o(busy)
  );

  assign tmr_en = (state_q != S_IDLE) && (state_q != S_WAIT);

  i2cm_half_timer #(.HALF_DIV(HALF_DIV)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tmr_en), .tick_o(tick)
  );

  assign start_go = ctrl_we_i && ctrl_mst_i && ctrl_trx_i && ctrl_bb_i && ctrl_pin_i
                    && (state_q == S_IDLE) && !busy;
  assign stop_go  = ctrl_we_i && ctrl_pin_i && !ctrl_bb_i && (state_q == S_WAIT);

  always_comb begin
    unique case (state_q)
      S_START, S_STOP_LO, S_STOP_HI: sda_nxt = 1'b1;
      S_BIT_LO, S_BIT_HI:            sda_nxt = ~shift_q[BITS-1];
      default:                       sda_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dbr_q <= '0;
    else if (data_we_i) dbr_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      shift_q  <= '0;
      bit_q    <= '0;
      dir_q    <= 1'b0;
      pin_q    <= 1'b1;
      trx_q    <= 1'b0;
      lrb_q    <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      // SDA follows the state one cycle late: data moves only after SCL fell
      sda_oe_q <= sda_nxt;
      unique case (state_q)
        S_IDLE: if (start_go) begin
          state_q <= S_START;
          shift_q <= dbr_q;
          dir_q   <= dbr_q[0];
          bit_q   <= BW'(BITS - 1);
          trx_q   <= 1'b1;
        end
        S_START:  if (tick) state_q <= S_BIT_LO;
        S_BIT_LO: if (tick) state_q <= S_BIT_HI;
        S_BIT_HI: if (tick) begin
          if (bit_q == '0) state_q <= S_ACK_LO;
          else begin
            bit_q   <= bit_q - BW'(1);
            shift_q <= shift_q << 1;
            state_q <= S_BIT_LO;
          end
        end
        S_ACK_LO: if (tick) state_q <= S_ACK_HI;
        S_ACK_HI: if (tick) begin
          lrb_q   <= sda_s;
          if (!sda_s) trx_q <= ~dir_q;
          pin_q   <= 1'b0;
          state_q <= S_WAIT;
        end
        S_WAIT: if (stop_go) begin
          pin_q   <= 1'b1;
          state_q <= S_STOP_LO;
        end
        S_STOP_LO:  if (tick) state_q <= S_STOP_HI;
        S_STOP_HI:  if (tick) state_q <= S_STOP_REL;
        S_STOP_REL: if (tick) state_q <= S_IDLE;
        default:    state_q <= S_IDLE;
      endcase
    end
  end

  assign scl_oe_o = (state_q == S_BIT_LO) || (state_q == S_ACK_LO) ||
                    (state_q == S_WAIT)   || (state_q == S_STOP_LO);
  assign sda_oe_o = sda_oe_q;
  assign busy_o   = busy;
  assign pin_o    = pin_q;
  assign trx_o    = trx_q;
  assign lrb_o    = lrb_q;
  assign irq_o    = ~pin_q;

  AST_START_NEEDS_FREE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_START && $past(state_q) == S_IDLE) |-> $past(!busy_o)); // R2
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BIT_HI && $past(state_q) == S_BIT_HI) |-> $stable(sda_oe_o)); // R4
  AST_ACK_SLOT_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ACK_HI) |-> !sda_oe_o); // R6
  AST_PEND_ON_NINTH_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_o) |-> ($past(state_q) == S_ACK_HI && scl_oe_o)); // R7
  AST_STRETCH_WHILE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_o |-> scl_oe_o); // R7
  AST_TRX_KEPT_ON_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pin_o) && lrb_o) |-> $stable(trx_o)); // R8
endmodule

// File: tb/i2c_addr_master_tb_top.sv
module i2c_addr_master_tb_top;
  localparam int unsigned HALF_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_we = 1'b0;
  logic [7:0] data = '0;
  logic ctrl_we = 1'b0, ctrl_mst = 1'b0, ctrl_trx = 1'b0, ctrl_bb = 1'b0, ctrl_pin = 1'b0;
  logic scl_oe, sda_oe, busy, pin, trx, lrb, irq;
  logic slv_oe = 1'b0, ext_sda = 1'b0, ack_en = 1'b0;
  logic scl_line, sda_line;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_oe | ext_sda);

  always #2.5ns clk = ~clk;

  i2c_addr_master #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_we_i(data_we), .data_i(data),
    .ctrl_we_i(ctrl_we), .ctrl_mst_i(ctrl_mst), .ctrl_trx_i(ctrl_trx),
    .ctrl_bb_i(ctrl_bb), .ctrl_pin_i(ctrl_pin), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .pin_o(pin),
    .trx_o(trx), .lrb_o(lrb), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // line monitor and target model, sampled away from the active edge
  bit   scl_prev = 1'b1, sda_prev = 1'b1, irq_prev = 1'b0, active = 1'b0, stop_seen = 1'b0, ack_drv = 1'b0;
  int   rises, falls, viol, act_cnt, hi_cnt, lo_cnt, hi_min, hi_max, lo_min, lo_max, irq_falls;
  logic [7:0] cap;

  always @(negedge clk) begin
    if (scl_oe || sda_oe) act_cnt++;
    if (scl_line && scl_prev && sda_prev && !sda_line) begin
      active = 1'b1; rises = 0; falls = 0; cap = '0; viol = 0; stop_seen = 1'b0; ack_drv = 1'b0;
      hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0; irq_falls = -1;
    end else if (scl_line && scl_prev && !sda_prev && sda_line) begin
      stop_seen = 1'b1; active = 1'b0;
    end else if (active && scl_line && scl_prev && (sda_line != sda_prev) && falls < 9) begin
      viol++;
    end
    if (active && scl_line && !scl_prev) begin
      if (rises < 8) cap = {cap[6:0], sda_line};
      if (rises < 9) begin
        if (lo_cnt < lo_min) lo_min = lo_cnt;
        if (lo_cnt > lo_max) lo_max = lo_cnt;
      end
      rises++; hi_cnt = 0;
    end
    if (active && !scl_line && scl_prev) begin
      if (rises > 0) begin
        falls++;
        if (falls <= 8) begin
          if (hi_cnt < hi_min) hi_min = hi_cnt;
          if (hi_cnt > hi_max) hi_max = hi_cnt;
        end
        if (falls == 8 && ack_en) slv_oe = 1'b1;
        if (falls == 9) slv_oe = 1'b0;
      end
      lo_cnt = 0;
    end
    if (scl_line) hi_cnt++; else lo_cnt++;
    if (active && rises == 9 && scl_line && sda_oe) ack_drv = 1'b1;
    if (irq && !irq_prev) irq_falls = falls;
    scl_prev = scl_line; sda_prev = sda_line; irq_prev = irq;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1ns;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) settle();
  endtask

  task automatic wr_data(input logic [7:0] d);
    @(negedge clk); data = d; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wr_ctrl(input bit m, input bit t, input bit b, input bit p);
    @(negedge clk); ctrl_mst = m; ctrl_trx = t; ctrl_bb = b; ctrl_pin = p; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  function automatic bit exp_trx(input bit dir, input bit ack);
    return ack ? ~dir : 1'b1;
  endfunction

  function automatic bit exp_lrb(input bit ack);
    return ~ack;
  endfunction

  task automatic do_txn(input logic [7:0] d, input bit ack);
    int t = 0;
    int w, low;
    ack_en = ack;
    wr_data(d);
    wr_ctrl(1'b1, 1'b1, 1'b1, 1'b1);
    while (!irq && t < 4000) begin settle(); t++; end
    chk(irq == 1'b1, "R7", "irq raised after address phase", int'(irq), 1);
    if (!irq) return;
    settle();
    chk(cap == d, "R4", "byte seen on bus", int'(cap), int'(d));
    chk(viol == 0, "R4", "SDA changes while SCL high", viol, 0);
    chk(hi_min == HALF_DIV && hi_max == HALF_DIV, "R5", "SCL high phase length", hi_max, HALF_DIV);
    chk(lo_min == HALF_DIV && lo_max == HALF_DIV, "R5", "SCL low phase length", lo_min, HALF_DIV);
    chk(ack_drv == 1'b0, "R6", "master drove SDA in ack slot", int'(ack_drv), 0);
    chk(lrb == exp_lrb(ack), "R6", "sampled ack level", int'(lrb), int'(exp_lrb(ack)));
    chk(irq_falls == 9, "R7", "SCL falls at interrupt", irq_falls, 9);
    chk(pin == 1'b0, "R7", "pending flag", int'(pin), 0);
    chk(trx == exp_trx(d[0], ack), "R8", "direction status", int'(trx), int'(exp_trx(d[0], ack)));
    chk(busy == 1'b1, "R3", "busy after START", int'(busy), 1);
    w = $urandom_range(40, 5);
    low = 0;
    repeat (w) begin settle(); if (!scl_line) low++; end
    chk(low == w, "R7", "SCL held low while pending", low, w);
    wr_ctrl(1'b0, 1'b0, 1'b0, 1'b1);
    t = 0;
    while (busy && t < 4000) begin settle(); t++; end
    chk(stop_seen && !busy, "R9", "STOP seen and bus free", int'(busy), 0);
    chk(pin == 1'b1 && !irq, "R9", "pending flag after stop", int'(pin), 1);
    wait_cyc(2 * HALF_DIV);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_cyc(3);
    chk(!scl_oe && !sda_oe, "R1", "line drive at reset", int'({scl_oe, sda_oe}), 0);
    chk(!busy && pin && !irq, "R1", "busy/pin/irq at reset", int'({busy, pin, irq}), 2);
    chk(!trx && !lrb, "R1", "trx/lrb at reset", int'({trx, lrb}), 0);
    rst_n = 1'b1;
    wait_cyc(5);
    chk(!scl_oe && !sda_oe && !busy && pin && !trx && !lrb && !irq, "R1", "state after reset release", int'(busy), 0);

    wr_data(8'hCB);
    act_cnt = 0;
    wr_ctrl(1'b1, 1'b1, 1'b0, 1'b1);
    wr_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
    wr_ctrl(1'b0, 1'b1, 1'b1, 1'b1);
    wait_cyc(40);
    chk(act_cnt == 0 && !busy, "R2", "line activity after partial command", act_cnt, 0);

    @(negedge clk); ext_sda = 1'b1;
    wait_cyc(10);
    chk(busy == 1'b1, "R3", "busy from foreign START", int'(busy), 1);
    act_cnt = 0;
    wr_ctrl(1'b1, 1'b1, 1'b1, 1'b1);
    wait_cyc(60);
    chk(act_cnt == 0, "R10", "activity while foreign master holds bus", act_cnt, 0);
    @(negedge clk); ext_sda = 1'b0;
    wait_cyc(10);
    chk(busy == 1'b0, "R3", "busy cleared by foreign STOP", int'(busy), 0);
    wait_cyc(40);
    chk(act_cnt == 0, "R10", "dropped command not replayed", act_cnt, 0);

    do_txn(8'hCB, 1'b1);
    do_txn(8'hCA, 1'b1);
    do_txn(8'hCB, 1'b0);
    do_txn(8'h00, 1'b1);
    do_txn(8'hFF, 1'b0);
    for (int i = 0; i < 30; i++) begin
      logic [7:0] d;
      bit a;
      d = 8'($urandom());
      a = 1'($urandom_range(1, 0));
      do_txn(d, a);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule